// File: doc/BRIEF.md
# Cross-Path Operand Selector

This block sits between two 16-entry, 32-bit register files (side A and side B) and eight functional units, four on each side. Each side holds one unit of each kind, in fixed slots: slot 0 is the logic/arithmetic unit (L-type), slot 1 the shift/branch unit (S-type), slot 2 the multiplier (M-type), and slot 3 the address/memory unit (D-type). Units 0 to 3 belong to side A and units 4 to 7 to side B. Every unit names a register for its src1 and src2 operands. Each source also carries a flag that asks to read from the opposite file instead of the unit's own file.

Each side has one cross bus, 32 bits wide. It carries a single register of the opposite file per execute packet. The block decides which requests may use the bus and which register the bus carries. It routes either that bus or the unit's own file to each source. An execute packet breaks the rules when a unit kind asks for a source it cannot take across, or when one side needs two different registers over its single bus. In either case the block raises a violation flag. Every result is registered, so operands and the flag appear one cycle after the packet is presented.

Top module: `xpath_select`

## Requirements
- R1: Outputs are registered. `outValid`, `violation`, `src1Data` and `src2Data` reflect the packet presented on the previous clock edge. An active-low reset clears all of them to zero.
- R2: A source without a cross request reads the unit's own file: units 0-3 read file A and units 4-7 read file B. Register r of a file sits at bits [r*32 +: 32] of `fileA`/`fileB`. The index of unit u sits at bits [u*4 +: 4] and its data at bits [u*32 +: 32].
- R3: A granted cross request from a side-A unit delivers a register of file B. A granted request from a side-B unit delivers a register of file A.
- R4: The slot-0 unit of either side may take src1, src2 or both across without a violation, provided it needs only one register.
- R5: Slot-1 and slot-2 units may take only src2 across. A src1 cross request on them sets `violation`, and that src1 reads the own-side register it names.
- R6: Slot-3 units have no cross access. A cross request on either of their sources sets `violation`, and the source reads the own-side register it names.
- R7: Several granted cross sources on one side that all name the same register each receive that register, and `violation` stays low.
- R8: If granted cross sources on one side name different registers, `violation` is set. The bus carries the register of the first granted request in the order slot-0 src1, slot-0 src2, slot-1 src2, slot-2 src2. Every granted source on that side receives that one value.
- R9: With `pktValid` low, the next cycle shows `outValid` and `violation` low. Both data outputs keep their previous values whatever the other inputs do.
- R10: The two sides' cross paths are independent. One cross read on each side in the same packet is legal, and each delivers its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pktValid | input | 1 | An execute packet is present this cycle |
| xReq1 | input | 8 | Per-unit request to take src1 from the opposite file |
| xReq2 | input | 8 | Per-unit request to take src2 from the opposite file |
| src1Idx | input | 32 | Per-unit src1 register index, 4 bits per unit |
| src2Idx | input | 32 | Per-unit src2 register index, 4 bits per unit |
| fileA | input | 512 | Contents of register file A, 16 x 32 bits |
| fileB | input | 512 | Contents of register file B, 16 x 32 bits |
| outValid | output | 1 | Operands below belong to a valid packet |
| src1Data | output | 256 | Selected src1 operand per unit, 32 bits per unit |
| src2Data | output | 256 | Selected src2 operand per unit, 32 bits per unit |
| violation | output | 1 | The packet broke a cross-path rule |

## Verification
A fault in the grant logic shows at the ports one cycle after the packet. If a disallowed slot is granted, it returns an opposite-file value where its own-file value was due, and `violation` may drop. If the bus arbitration is wrong, every granted source on that side carries the wrong register. Because the two files hold disjoint value patterns, any misrouted operand differs from the expected word in its top byte. The bench can therefore tell a wrong file from a wrong index. A load strobe that does not honour `pktValid` shows up as changed operands on the first idle cycle.

// File: rtl/xpath_pkg.sv
package xpath_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned REG_COUNT = 16;
  localparam int unsigned IDX_W     = $clog2(REG_COUNT);
  localparam int unsigned SIDES     = 2;
  localparam int unsigned PER_SIDE  = 4;
  localparam int unsigned UNITS     = SIDES * PER_SIDE;
  localparam int unsigned FILE_W    = REG_COUNT * DATA_W;

  typedef enum logic [1:0] {
    SLOT_L = 2'd0,
    SLOT_S = 2'd1,
    SLOT_M = 2'd2,
    SLOT_D = 2'd3
  } unit_slot_e;

  // Strobes from the control to the datapath, one execute packet's worth.
  typedef struct packed {
    logic [UNITS-1:0]            take1;
    logic [UNITS-1:0]            take2;
    logic [SIDES-1:0][IDX_W-1:0] busIdx;
    logic                        viol;
    logic                        load;
  } xpath_strobe_t;
endpackage

// File: rtl/xpath_ctrl.sv
module xpath_ctrl
  import xpath_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   pktValid,
  input  logic [UNITS-1:0]       xReq1,
  input  logic [UNITS-1:0]       xReq2,
  input  logic [UNITS*IDX_W-1:0] src1Idx,
  input  logic [UNITS*IDX_W-1:0] src2Idx,
  output xpath_strobe_t          strb
);

  logic [SIDES-1:0] busUsed;
  logic             ruleBroken;

  always_comb begin
    strb       = '0;
    busUsed    = '0;
    ruleBroken = 1'b0;
    strb.load  = pktValid;
    for (int s = 0; s < SIDES; s++) begin
      for (int k = 0; k < PER_SIDE; k++) begin
        // src1 first, then src2, so the bus priority follows slot then source
        if (xReq1[s*PER_SIDE+k]) begin
          if (unit_slot_e'(k) == SLOT_L) begin
            strb.take1[s*PER_SIDE+k] = 1'b1;
            if (!busUsed[s]) begin
              busUsed[s]     = 1'b1;
              strb.busIdx[s] = src1Idx[(s*PER_SIDE+k)*IDX_W +: IDX_W];
            end else if (strb.busIdx[s] != src1Idx[(s*PER_SIDE+k)*IDX_W +: IDX_W]) begin
              ruleBroken = 1'b1;
            end
          end else begin
            ruleBroken = 1'b1;
          end
        end
        if (xReq2[s*PER_SIDE+k]) begin
          if (unit_slot_e'(k) != SLOT_D) begin
            strb.take2[s*PER_SIDE+k] = 1'b1;
            if (!busUsed[s]) begin
              busUsed[s]     = 1'b1;
              strb.busIdx[s] = src2Idx[(s*PER_SIDE+k)*IDX_W +: IDX_W];
            end else if (strb.busIdx[s] != src2Idx[(s*PER_SIDE+k)*IDX_W +: IDX_W]) begin
              ruleBroken = 1'b1;
            end
          end else begin
            ruleBroken = 1'b1;
          end
        end
      end
    end
    strb.viol = pktValid & ruleBroken;
  end

  // R6: a grant is only ever issued where a request exists
  p_grant_needs_request_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.take1 & ~xReq1) == '0) && ((strb.take2 & ~xReq2) == '0));

  // R5: src1 is never granted on a non-L slot
  p_src1_only_slot0_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.take1 & 8'b1110_1110) == '0);

endmodule

// File: rtl/xpath_datapath.sv
module xpath_datapath
  import xpath_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  xpath_strobe_t           strb,
  input  logic [UNITS*IDX_W-1:0]  src1Idx,
  input  logic [UNITS*IDX_W-1:0]  src2Idx,
  input  logic [FILE_W-1:0]       fileA,
  input  logic [FILE_W-1:0]       fileB,
  output logic                    outValid,
  output logic [UNITS*DATA_W-1:0] src1Data,
  output logic [UNITS*DATA_W-1:0] src2Data,
  output logic                    violation
);

  logic [SIDES-1:0][DATA_W-1:0] xBus;
  logic [UNITS*DATA_W-1:0]      next1;
  logic [UNITS*DATA_W-1:0]      next2;

  for (genvar s = 0; s < SIDES; s++) begin : g_bus
    if (s == 0) begin : g_a
      assign xBus[s] = fileB[strb.busIdx[s]*DATA_W +: DATA_W];
    end else begin : g_b
      assign xBus[s] = fileA[strb.busIdx[s]*DATA_W +: DATA_W];
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_unit
    localparam int unsigned SIDE = u / PER_SIDE;
    logic [IDX_W-1:0]  idx1, idx2;
    logic [DATA_W-1:0] own1, own2;
    assign idx1 = src1Idx[u*IDX_W +: IDX_W];
    assign idx2 = src2Idx[u*IDX_W +: IDX_W];
    if (SIDE == 0) begin : g_own_a
      assign own1 = fileA[idx1*DATA_W +: DATA_W];
      assign own2 = fileA[idx2*DATA_W +: DATA_W];
    end else begin : g_own_b
      assign own1 = fileB[idx1*DATA_W +: DATA_W];
      assign own2 = fileB[idx2*DATA_W +: DATA_W];
    end
    assign next1[u*DATA_W +: DATA_W] = strb.take1[u] ? xBus[SIDE] : own1;
    assign next2[u*DATA_W +: DATA_W] = strb.take2[u] ? xBus[SIDE] : own2;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      violation <= 1'b0;
      src1Data  <= '0;
      src2Data  <= '0;
    end else begin
      outValid  <= strb.load;
      violation <= strb.viol;
      if (strb.load) begin
        src1Data <= next1;
        src2Data <= next2;
      end
    end
  end

  // R1: a loaded packet is flagged valid on the following cycle
  p_load_to_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> outValid);

  // R9: operand registers hold while nothing is loaded
  p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> ($stable(src1Data) && $stable(src2Data)));

endmodule

// File: rtl/xpath_select.sv
module xpath_select
  import xpath_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    pktValid,
  input  logic [UNITS-1:0]        xReq1,
  input  logic [UNITS-1:0]        xReq2,
  input  logic [UNITS*IDX_W-1:0]  src1Idx,
  input  logic [UNITS*IDX_W-1:0]  src2Idx,
  input  logic [FILE_W-1:0]       fileA,
  input  logic [FILE_W-1:0]       fileB,
  output logic                    outValid,
  output logic [UNITS*DATA_W-1:0] src1Data,
  output logic [UNITS*DATA_W-1:0] src2Data,
  output logic                    violation
);

  xpath_strobe_t strb;

  xpath_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid),
    .xReq1(xReq1), .xReq2(xReq2),
    .src1Idx(src1Idx), .src2Idx(src2Idx),
    .strb(strb)
  );

  xpath_datapath i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .src1Idx(src1Idx), .src2Idx(src2Idx),
    .fileA(fileA), .fileB(fileB),
    .outValid(outValid), .src1Data(src1Data), .src2Data(src2Data),
    .violation(violation)
  );

  // R6: a D-slot cross request always flags the packet
  p_dslot_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && (xReq1[3] || xReq2[3] || xReq1[7] || xReq2[7])) |=> violation);

  // R5: src1 cross on S or M slots always flags the packet
  p_sm_src1_flags_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && ((xReq1 & 8'b0110_0110) != '0)) |=> violation);

  // R2: a packet with no cross requests is never flagged
  p_no_req_clean_r2: assert property (@(posedge clk) disable iff (!rstN)
    (pktValid && xReq1 == '0 && xReq2 == '0) |=> !violation);

  // R9: idle cycles produce neither valid nor violation
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !pktValid |=> (!outValid && !violation));

endmodule

// File: tb/test_xpath_select.sv
module test_xpath_select;
  import xpath_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    pktValid = 1'b0;
  logic [UNITS-1:0]        xReq1 = '0;
  logic [UNITS-1:0]        xReq2 = '0;
  logic [UNITS*IDX_W-1:0]  src1Idx = '0;
  logic [UNITS*IDX_W-1:0]  src2Idx = '0;
  logic [FILE_W-1:0]       fileA;
  logic [FILE_W-1:0]       fileB;
  logic                    outValid;
  logic [UNITS*DATA_W-1:0] src1Data;
  logic [UNITS*DATA_W-1:0] src2Data;
  logic                    violation;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xpath_select i_xpath_select (
    .clk(clk), .rstN(rstN), .pktValid(pktValid),
    .xReq1(xReq1), .xReq2(xReq2),
    .src1Idx(src1Idx), .src2Idx(src2Idx),
    .fileA(fileA), .fileB(fileB),
    .outValid(outValid), .src1Data(src1Data), .src2Data(src2Data),
    .violation(violation)
  );

  function automatic logic [31:0] valA(int r);
    return 32'hA0A0_0000 + 32'(r) * 32'h111;
  endfunction
  function automatic logic [31:0] valB(int r);
    return 32'hB0B0_0000 + 32'(r) * 32'h111;
  endfunction

  initial begin
    for (int r = 0; r < REG_COUNT; r++) begin
      fileA[r*DATA_W +: DATA_W] = valA(r);
      fileB[r*DATA_W +: DATA_W] = valB(r);
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk1(string tag, int u, logic [31:0] exp);
    check(tag, $sformatf("src1 unit %0d", u), src1Data[u*DATA_W +: DATA_W], exp);
  endtask
  task automatic chk2(string tag, int u, logic [31:0] exp);
    check(tag, $sformatf("src2 unit %0d", u), src2Data[u*DATA_W +: DATA_W], exp);
  endtask
  task automatic chkFlags(string tag, logic expValid, logic expViol);
    check(tag, "outValid", {31'd0, outValid}, {31'd0, expValid});
    check(tag, "violation", {31'd0, violation}, {31'd0, expViol});
  endtask

  // Default packet: no requests, src1 of unit u names register u, src2 names u+8.
  task automatic clearPkt();
    xReq1 = '0;
    xReq2 = '0;
    for (int u = 0; u < UNITS; u++) begin
      src1Idx[u*IDX_W +: IDX_W] = IDX_W'(u);
      src2Idx[u*IDX_W +: IDX_W] = IDX_W'((u + 8) % REG_COUNT);
    end
  endtask

  task automatic set1(int u, int r);
    xReq1[u] = 1'b1;
    src1Idx[u*IDX_W +: IDX_W] = IDX_W'(r);
  endtask
  task automatic set2(int u, int r);
    xReq2[u] = 1'b1;
    src2Idx[u*IDX_W +: IDX_W] = IDX_W'(r);
  endtask

  // Present the packet at the falling edge; look at the outputs a quarter
  // period after the next rising edge, where the registered result lands.
  task automatic send(logic valid);
    pktValid = valid;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic prep();
    @(negedge clk);
    clearPkt();
  endtask

  task automatic t_reset();
    check("R1", "src1 after reset", src1Data[31:0], 32'h0);
    check("R1", "src2 after reset", src2Data[255:224], 32'h0);
    chkFlags("R1", 1'b0, 1'b0);
  endtask

  task automatic t_same_side();
    prep();
    send(1'b1);
    chkFlags("R2", 1'b1, 1'b0);
    chk1("R2", 0, valA(0));
    chk2("R2", 3, valA(11));
    chk1("R2", 5, valB(5));
    chk2("R2", 7, valB(15));
  endtask

  task automatic t_l_both();
    prep();
    set1(0, 6);
    set2(0, 6);
    set1(4, 2);
    send(1'b1);
    chkFlags("R4", 1'b1, 1'b0);
    chk1("R4", 0, valB(6));
    chk2("R4", 0, valB(6));
    chk1("R3", 4, valA(2));
    chk2("R3", 4, valB(12));
  endtask

  task automatic t_sm_src2();
    prep();
    set2(1, 9);
    send(1'b1);
    chkFlags("R5", 1'b1, 1'b0);
    chk2("R5", 1, valB(9));
    prep();
    set1(2, 3);
    send(1'b1);
    chkFlags("R5", 1'b1, 1'b1);
    chk1("R5", 2, valA(3));
    prep();
    set1(5, 1);
    send(1'b1);
    chkFlags("R5", 1'b1, 1'b1);
    chk1("R5", 5, valB(1));
  endtask

  task automatic t_dslot();
    prep();
    set2(7, 4);
    send(1'b1);
    chkFlags("R6", 1'b1, 1'b1);
    chk2("R6", 7, valB(4));
    prep();
    set1(3, 1);
    send(1'b1);
    chkFlags("R6", 1'b1, 1'b1);
    chk1("R6", 3, valA(1));
  endtask

  task automatic t_share();
    prep();
    set2(1, 12);
    set2(2, 12);
    set1(0, 12);
    send(1'b1);
    chkFlags("R7", 1'b1, 1'b0);
    chk2("R7", 1, valB(12));
    chk2("R7", 2, valB(12));
    chk1("R7", 0, valB(12));
  endtask

  task automatic t_conflict();
    prep();
    set2(5, 3);
    set2(4, 10);
    send(1'b1);
    chkFlags("R8", 1'b1, 1'b1);
    chk2("R8", 4, valA(10));
    chk2("R8", 5, valA(10));
    prep();
    set1(0, 2);
    set2(0, 7);
    send(1'b1);
    chkFlags("R8", 1'b1, 1'b1);
    chk1("R8", 0, valB(2));
    chk2("R8", 0, valB(2));
    prep();
    set2(2, 14);
    set2(1, 5);
    send(1'b1);
    chkFlags("R8", 1'b1, 1'b1);
    chk2("R8", 1, valB(5));
    chk2("R8", 2, valB(5));
  endtask

  task automatic t_idle();
    prep();
    set2(1, 9);
    send(1'b1);
    chk2("R9", 1, valB(9));
    prep();
    set2(3, 0);
    set1(1, 4);
    src1Idx[0 +: IDX_W] = IDX_W'(15);
    send(1'b0);
    chkFlags("R9", 1'b0, 1'b0);
    chk2("R9", 1, valB(9));
    chk1("R9", 0, valA(0));
    chk2("R9", 3, valA(11));
  endtask

  task automatic t_sides();
    prep();
    set2(1, 5);
    set2(6, 8);
    send(1'b1);
    chkFlags("R10", 1'b1, 1'b0);
    chk2("R10", 1, valB(5));
    chk2("R10", 6, valA(8));
    chk1("R10", 1, valA(1));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    clearPkt();
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    t_same_side();
    t_l_both();
    t_sm_src2();
    t_dslot();
    t_share();
    t_conflict();
    t_idle();
    t_sides();
    finish();
  end

endmodule